// File: doc/BRIEF.md
# S/PDIF Serial Audio Transmitter

This block turns PCM or raw data samples into an IEC 60958 biphase-mark bit stream on a single output line. A host programs it through a small word-wide register port. The port sets a divide ratio for the master clock, the sample width, stereo or single-channel operation, a non-audio flag, and the 42 channel-status bits that the block sends, one per frame. Samples come from a transmit FIFO through a valid/ready handshake. The block takes one sample at the start of each subframe, or one per frame in single-channel mode.

The divided clock gives one tick per biphase half-cell. One subframe is 32 cells (64 half-cells) and one frame is two subframes, so the line runs at 128 times the sample rate. For 48 kHz from a 24.576 MHz master clock the host writes ratio field 3. Each subframe carries a 4-cell preamble, 24 audio slots, validity, user, channel-status and an even-parity bit. Frames are counted in blocks of 192.

Top module: `spdif_tx`

## Requirements
- R1: After reset every register reads zero, `spdif_out` is low and `smp_ready` is low.
- R2: The line stays low and no sample is taken unless both the global enable (address 0, bit 1) and the transmit enable (address 1, bit 0) are set.
- R3: Each half-cell lasts exactly ratio+1 clock cycles, where ratio is address 1 bits 8:4. The line only changes at half-cell boundaries.
- R4: Subframe slots are: preamble in cells 0-3; audio in cells 4-27 with the LSB first; validity in cell 28; user (always 0) in cell 29; channel status in cell 30; parity in cell 31. Parity makes cells 4-31 even. Every data cell begins with a transition, and a 1 adds a mid-cell transition.
- R5: The preamble half-cell patterns, first half first, relative to a low preceding level, are B = 11101000, M = 11100010 and W = 11100100. They are inverted when the preceding level is high. Left subframes of frame 0 of each 192-frame block use B, other left subframes use M, and right subframes use W.
- R6: The sample is 24 bits with its MSB at bit 23. Format field (address 1 bits 3:2) code 0 sends bits 23:8 in cells 12-27 with cells 4-11 zero. Code 1 sends bits 23:4 in cells 8-27. Codes 2 and 3 send all 24 bits.
- R7: In stereo, `smp_ready` is high for one cycle at the start of each subframe, left first. A sample transfers when `smp_valid` and `smp_ready` are both high. With address 1 bit 31 set, one sample is taken per frame and is sent in both subframes.
- R8: A subframe that finds no valid sample sends zero audio with validity 1.
- R9: With the non-audio flag (address 1 bit 16) set, validity is 1 in every subframe. When status comes from the registers, the status bit of frame 1 is forced to 1.
- R10: With address 1 bit 1 set, both subframes of frame n carry bit n of {address 3 bits 9:0, address 2} for n < 42, and 0 for frames 42-191. With bit 1 clear, the status bit is always 0.
- R11: Address 0 holds the global enable. Writing 1 to address 0 bit 0 clears all registers and reads back 0. Address 1 keeps only bits 31, 16 and 8:0. Address 2 keeps 32 bits and address 3 keeps bits 9:0. Unkept bits read 0.
- R12: A soft reset during transmission returns the line to low and keeps it there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| smp_valid | input | 1 | FIFO has a sample |
| smp_data | input | 24 | Sample, MSB-justified |
| smp_ready | output | 1 | Block takes the sample this cycle |
| spdif_out | output | 1 | Biphase-mark serial line |

## Verification
Register reads are due in the same cycle, and a write acts at the next rising edge. After both enables are set, the first line edge comes ratio+1 cycles later, and each later half-cell lasts another ratio+1 cycles. So the bench waits for the first rising edge of a B preamble and records the line at every falling clock edge. From that record it takes one level per half-cell, every ratio+1 samples. It also checks that the level stays constant within each half-cell and that the first high run lasts three half-cells. Subframes, preambles and status bits are then decoded from these half-cell levels. The handshake is sampled at the rising edge, where `smp_ready` coincides with the first tick of a subframe.

// File: rtl/spdif_tx_pkg.sv
package spdif_tx_pkg;

    localparam int REG_W          = 32;
    localparam int AUDIO_SLOTS    = 24;
    localparam int RATIO_W        = 5;
    localparam int CS_LO_W        = 32;
    localparam int CS_HI_W        = 10;
    localparam int CS_BITS        = CS_LO_W + CS_HI_W;
    localparam int BLOCK_FRAMES   = 192;
    localparam int FRAME_W        = $clog2(BLOCK_FRAMES);
    localparam int CELLS_PER_SUB  = 32;
    localparam int HALVES_PER_SUB = 2 * CELLS_PER_SUB;
    localparam int HC_W           = $clog2(HALVES_PER_SUB);
    localparam int PRE_HALVES     = 8;
    localparam int SLOT_AUDIO     = 4;
    localparam int SLOT_VALID     = SLOT_AUDIO + AUDIO_SLOTS;
    localparam int SLOT_USER      = SLOT_VALID + 1;
    localparam int SLOT_CSTAT     = SLOT_USER + 1;
    localparam int SLOT_PARITY    = SLOT_CSTAT + 1;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_CFG  = 2'd1;
    localparam logic [1:0] ADDR_CS0  = 2'd2;
    localparam logic [1:0] ADDR_CS1  = 2'd3;

    localparam int CTRL_SRST  = 0;
    localparam int CTRL_GEN   = 1;
    localparam int CFG_EN     = 0;
    localparam int CFG_CSREG  = 1;
    localparam int CFG_FMT_LO = 2;
    localparam int CFG_RAT_LO = 4;
    localparam int CFG_NAUD   = 16;
    localparam int CFG_MONO   = 31;

    typedef enum logic [1:0] {
        FMT_16  = 2'd0,
        FMT_20  = 2'd1,
        FMT_24  = 2'd2,
        FMT_RSV = 2'd3
    } smp_fmt_e;

    typedef enum logic [1:0] {
        PRE_B = 2'd0,
        PRE_M = 2'd1,
        PRE_W = 2'd2
    } pre_e;

    typedef struct packed {
        logic                 mono;
        logic                 nonaudio;
        logic [RATIO_W-1:0]   ratio;
        smp_fmt_e             fmt;
        logic                 cs_from_reg;
        logic                 tx_en;
    } tx_cfg_t;

    function automatic logic [PRE_HALVES-1:0] pre_pattern(input pre_e kind);
        case (kind)
            PRE_B:   return 8'b1110_1000;
            PRE_M:   return 8'b1110_0010;
            default: return 8'b1110_0100;
        endcase
    endfunction

endpackage

// File: rtl/spdif_tx_regs.sv
module spdif_tx_regs
    import spdif_tx_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [1:0]         addr,
    input  logic [REG_W-1:0]   wdata,
    output logic [REG_W-1:0]   rdata,
    output tx_cfg_t            cfg,
    output logic [CS_BITS-1:0] cs_vec,
    output logic               run
);

    typedef struct packed {
        logic                gen;
        tx_cfg_t             cfg;
        logic [CS_LO_W-1:0]  cs_lo;
        logic [CS_HI_W-1:0]  cs_hi;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (we) begin
            unique case (addr)
                ADDR_CTRL: begin
                    if (wdata[CTRL_SRST]) begin
                        regs_d = '0;
                    end else begin
                        regs_d.gen = wdata[CTRL_GEN];
                    end
                end
                ADDR_CFG: begin
                    regs_d.cfg.mono        = wdata[CFG_MONO];
                    regs_d.cfg.nonaudio    = wdata[CFG_NAUD];
                    regs_d.cfg.ratio       = wdata[CFG_RAT_LO +: RATIO_W];
                    regs_d.cfg.fmt         = smp_fmt_e'(wdata[CFG_FMT_LO +: 2]);
                    regs_d.cfg.cs_from_reg = wdata[CFG_CSREG];
                    regs_d.cfg.tx_en       = wdata[CFG_EN];
                end
                ADDR_CS0: regs_d.cs_lo = wdata[CS_LO_W-1:0];
                default:  regs_d.cs_hi = wdata[CS_HI_W-1:0];
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            ADDR_CTRL: rdata[CTRL_GEN] = regs_q.gen;
            ADDR_CFG: begin
                rdata[CFG_MONO]                = regs_q.cfg.mono;
                rdata[CFG_NAUD]                = regs_q.cfg.nonaudio;
                rdata[CFG_RAT_LO +: RATIO_W]   = regs_q.cfg.ratio;
                rdata[CFG_FMT_LO +: 2]         = regs_q.cfg.fmt;
                rdata[CFG_CSREG]               = regs_q.cfg.cs_from_reg;
                rdata[CFG_EN]                  = regs_q.cfg.tx_en;
            end
            ADDR_CS0: rdata[CS_LO_W-1:0] = regs_q.cs_lo;
            default:  rdata[CS_HI_W-1:0] = regs_q.cs_hi;
        endcase
    end

    assign cfg    = regs_q.cfg;
    assign cs_vec = {regs_q.cs_hi, regs_q.cs_lo};
    assign run    = regs_q.gen & regs_q.cfg.tx_en;

endmodule

// File: rtl/spdif_tx_div.sv
module spdif_tx_div #(
    parameter int RW = spdif_tx_pkg::RATIO_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [RW-1:0] ratio,
    output logic          tick
);

    typedef struct packed {
        logic [RW-1:0] cnt;
    } div_t;

    div_t div_d, div_q;

    always_comb begin
        div_d = div_q;
        tick  = 1'b0;
        if (!run) begin
            div_d.cnt = '0;
        end else if (div_q.cnt >= ratio) begin
            div_d.cnt = '0;
            tick      = 1'b1;
        end else begin
            div_d.cnt = div_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

endmodule

// File: rtl/spdif_tx_word.sv
module spdif_tx_word
    import spdif_tx_pkg::*;
(
    input  logic [AUDIO_SLOTS-1:0] smp,
    input  logic                   have,
    input  smp_fmt_e               fmt,
    input  logic                   nonaudio,
    input  logic                   cstat,
    output logic [CELLS_PER_SUB-1:0] word
);

    int unsigned              drop;
    logic [AUDIO_SLOTS-1:0]   audio;

    always_comb begin
        unique case (fmt)
            FMT_16:  drop = 8;
            FMT_20:  drop = 4;
            default: drop = 0;
        endcase
        for (int i = 0; i < AUDIO_SLOTS; i++) begin
            audio[i] = have && smp[i] && (i >= drop);
        end
        word                          = '0;
        word[SLOT_AUDIO +: AUDIO_SLOTS] = audio;
        word[SLOT_VALID]              = nonaudio || !have;
        word[SLOT_USER]               = 1'b0;
        word[SLOT_CSTAT]              = cstat;
        word[SLOT_PARITY]             = ^word[SLOT_CSTAT:SLOT_AUDIO];
    end

endmodule

// File: rtl/spdif_tx_enc.sv
module spdif_tx_enc
    import spdif_tx_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     run,
    input  logic                     tick,
    input  logic [CELLS_PER_SUB-1:0] word_in,
    output logic                     load,
    output logic [HC_W-1:0]          hc,
    output logic                     sub,
    output logic [FRAME_W-1:0]       frame,
    output logic                     line
);

    typedef struct packed {
        logic [HC_W-1:0]          hc;
        logic                     sub;
        logic [FRAME_W-1:0]       frame;
        logic                     line;
        logic                     base;
        logic [CELLS_PER_SUB-1:0] word;
    } enc_t;

    enc_t enc_d, enc_q;
    pre_e                  kind;
    logic [PRE_HALVES-1:0] pat;
    logic                  ref_lvl;

    always_comb begin
        if (enc_q.sub)                 kind = PRE_W;
        else if (enc_q.frame == '0)    kind = PRE_B;
        else                           kind = PRE_M;
        pat     = pre_pattern(kind);
        ref_lvl = (enc_q.hc == '0) ? enc_q.line : enc_q.base;
        load    = run && tick && (enc_q.hc == '0);

        enc_d = enc_q;
        if (!run) begin
            enc_d = '0;
        end else if (tick) begin
            if (enc_q.hc == '0) begin
                enc_d.word = word_in;
                enc_d.base = enc_q.line;
            end
            if (enc_q.hc < HC_W'(PRE_HALVES)) begin
                enc_d.line = pat[3'(PRE_HALVES - 1) - enc_q.hc[2:0]] ^ ref_lvl;
            end else if (!enc_q.hc[0]) begin
                enc_d.line = ~enc_q.line;
            end else begin
                enc_d.line = enc_q.line ^ enc_q.word[enc_q.hc[HC_W-1:1]];
            end
            enc_d.hc = enc_q.hc + 1'b1;
            if (enc_q.hc == HC_W'(HALVES_PER_SUB - 1)) begin
                enc_d.sub = ~enc_q.sub;
                if (enc_q.sub) begin
                    enc_d.frame = (enc_q.frame == FRAME_W'(BLOCK_FRAMES - 1))
                                ? '0 : enc_q.frame + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) enc_q <= '0;
        else        enc_q <= enc_d;
    end

    assign hc    = enc_q.hc;
    assign sub   = enc_q.sub;
    assign frame = enc_q.frame;
    assign line  = enc_q.line;

endmodule

// File: rtl/spdif_tx.sv
module spdif_tx
    import spdif_tx_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reg_we,
    input  logic [1:0]             reg_addr,
    input  logic [REG_W-1:0]       reg_wdata,
    output logic [REG_W-1:0]       reg_rdata,
    input  logic                   smp_valid,
    input  logic [AUDIO_SLOTS-1:0] smp_data,
    output logic                   smp_ready,
    output logic                   spdif_out
);

    localparam int CS_IDX_W = $clog2(CS_BITS);

    typedef struct packed {
        logic                   ok;
        logic [AUDIO_SLOTS-1:0] data;
    } hold_t;

    tx_cfg_t                  cfg;
    logic [CS_BITS-1:0]       cs_vec;
    logic                     run;
    logic                     tick;
    logic                     load;
    logic [HC_W-1:0]          hc;
    logic                     sub;
    logic [FRAME_W-1:0]       frame;
    logic [CELLS_PER_SUB-1:0] word;
    hold_t                    hold_d, hold_q;
    logic                     taken;
    logic                     use_hold;
    logic [AUDIO_SLOTS-1:0]   sel_smp;
    logic                     sel_ok;
    logic                     cstat;

    spdif_tx_regs u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (reg_we),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .rdata  (reg_rdata),
        .cfg    (cfg),
        .cs_vec (cs_vec),
        .run    (run)
    );

    spdif_tx_div #(.RW(RATIO_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .ratio (cfg.ratio),
        .tick  (tick)
    );

    always_comb begin
        smp_ready = load && (!cfg.mono || !sub);
        taken     = smp_ready && smp_valid;
        use_hold  = cfg.mono && sub;
        sel_smp   = use_hold ? hold_q.data : smp_data;
        sel_ok    = use_hold ? hold_q.ok   : taken;

        cstat = 1'b0;
        if (cfg.cs_from_reg) begin
            if (frame < FRAME_W'(CS_BITS)) begin
                cstat = cs_vec[frame[CS_IDX_W-1:0]];
            end
            if (cfg.nonaudio && (frame == FRAME_W'(1))) begin
                cstat = 1'b1;
            end
        end

        hold_d = hold_q;
        if (!run) begin
            hold_d = '0;
        end else if (load && !sub) begin
            hold_d.ok   = taken;
            hold_d.data = smp_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hold_q <= '0;
        else        hold_q <= hold_d;
    end

    spdif_tx_word u_word (
        .smp      (sel_smp),
        .have     (sel_ok),
        .fmt      (cfg.fmt),
        .nonaudio (cfg.nonaudio),
        .cstat    (cstat),
        .word     (word)
    );

    spdif_tx_enc u_enc (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .tick    (tick),
        .word_in (word),
        .load    (load),
        .hc      (hc),
        .sub     (sub),
        .frame   (frame),
        .line    (spdif_out)
    );

endmodule

// File: rtl/spdif_tx_checker.sv
module spdif_tx_checker
    import spdif_tx_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            run,
    input logic            tick,
    input logic [HC_W-1:0] hc,
    input logic            smp_ready,
    input logic            spdif_out,
    input logic            reg_we,
    input logic [1:0]      reg_addr,
    input logic            wbit0
);

    assert_idle_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !spdif_out);

    assert_ready_needs_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
        smp_ready |-> (run && tick));

    assert_ready_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        smp_ready |=> !smp_ready);

    assert_hold_between_ticks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick) |=> $stable(spdif_out));

    assert_cell_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && (hc >= HC_W'(PRE_HALVES)) && !hc[0])
        |=> (spdif_out != $past(spdif_out)));

    assert_soft_reset_stops_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && (reg_addr == ADDR_CTRL) && wbit0) |=> !run);

endmodule

bind spdif_tx spdif_tx_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .tick      (tick),
    .hc        (hc),
    .smp_ready (smp_ready),
    .spdif_out (spdif_out),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .wbit0     (reg_wdata[0])
);

// File: tb/spdif_tx_test.sv
module spdif_tx_test;

    localparam int CLK_PERIOD = 10;
    localparam int RAW_MAX    = 32768;
    localparam int NVEC       = 6;

    typedef struct packed {
        logic [4:0]  ratio;
        logic [1:0]  fmt;
        logic        mono;
        logic        na;
        logic [3:0]  nsmp;
        logic [23:0] sl;
        logic [23:0] sr;
        logic [23:0] el;
        logic [23:0] er;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{5'd0, 2'd2, 1'b0, 1'b0, 4'd8, 24'h123456, 24'hABCDEF, 24'h123456, 24'hABCDEF},
        '{5'd3, 2'd0, 1'b0, 1'b0, 4'd8, 24'h89ABCD, 24'h7F00FF, 24'h89AB00, 24'h7F0000},
        '{5'd1, 2'd1, 1'b0, 1'b0, 4'd8, 24'hFEDCBA, 24'h00000F, 24'hFEDCB0, 24'h000000},
        '{5'd2, 2'd3, 1'b1, 1'b0, 4'd8, 24'h555555, 24'hAAAAAA, 24'h555555, 24'hAAAAAA},
        '{5'd0, 2'd2, 1'b0, 1'b1, 4'd8, 24'h000001, 24'h800000, 24'h000001, 24'h800000},
        '{5'd5, 2'd2, 1'b0, 1'b0, 4'd1, 24'h0F0F0F, 24'h000000, 24'h0F0F0F, 24'h000000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        smp_valid;
    logic [23:0] smp_data;
    logic        smp_ready;
    logic        spdif_out;

    logic [23:0] fifo_mem [0:15];
    int          fifo_n = 0;
    int          rd_idx = 0;
    logic        fifo_clr = 1'b0;

    logic        raw [0:RAW_MAX-1];
    int          H = 1;
    int          n_checks = 0;
    int          n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign smp_valid = (rd_idx < fifo_n);
    assign smp_data  = (rd_idx < 16) ? fifo_mem[rd_idx] : 24'h0;

    always @(posedge clk) begin
        if (fifo_clr)                    rd_idx <= 0;
        else if (smp_valid && smp_ready) rd_idx <= rd_idx + 1;
    end

    spdif_tx uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .smp_ready (smp_ready),
        .spdif_out (spdif_out)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    function automatic logic [31:0] mk_cfg(input logic mono, input logic na,
                                           input logic [4:0] ratio, input logic [1:0] fmt,
                                           input logic csel, input logic en);
        return {mono, 14'b0, na, 7'b0, ratio, fmt, csel, en};
    endfunction

    task automatic soft_reset();
        wr(2'd0, 32'h1);
    endtask

    task automatic set_fifo(input int n, input logic [23:0] a, input logic [23:0] b);
        @(negedge clk); fifo_clr = 1'b1;
        @(negedge clk); fifo_clr = 1'b0;
        for (int i = 0; i < 16; i++) fifo_mem[i] = (i % 2 == 0) ? a : b;
        fifo_n = n;
    endtask

    task automatic capture(input int ncyc);
        int guard;
        guard = 0;
        while (spdif_out !== 1'b1 && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        for (int j = 0; j < ncyc; j++) begin
            raw[j] = spdif_out;
            @(negedge clk);
        end
    endtask

    function automatic logic hv(input int k);
        return raw[k * H];
    endfunction

    task automatic decode(input int s, output logic [7:0] pre,
                          output logic [31:0] w, output int berr);
        int st;
        logic prev;
        st   = s * 64;
        prev = (s == 0) ? 1'b0 : hv(st - 1);
        berr = 0;
        w    = '0;
        for (int i = 0; i < 8; i++) pre[7 - i] = hv(st + i) ^ prev;
        for (int c = 4; c < 32; c++) begin
            w[c] = (hv(st + 2*c) != hv(st + 2*c + 1));
            if (hv(st + 2*c) == hv(st + 2*c - 1)) berr++;
        end
    endtask

    function automatic logic [7:0] exp_pre(input int s);
        if (s % 2 == 1) return 8'b1110_0100;
        if ((s / 2) % 192 == 0) return 8'b1110_1000;
        return 8'b1110_0010;
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        logic [31:0] r;
        logic [7:0]  pre;
        logic [31:0] w;
        int          berr;
        int          cnt;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), r);
            check(r == 32'h0, "R1", "register after reset", r, 32'h0);
        end
        check(spdif_out == 1'b0, "R1", "line after reset", 32'(spdif_out), 32'h0);
        check(smp_ready == 1'b0, "R1", "ready after reset", 32'(smp_ready), 32'h0);

        // R2: only one enable set
        set_fifo(4, 24'h111111, 24'h222222);
        wr(2'd1, mk_cfg(0, 0, 5'd0, 2'd2, 0, 1));
        cnt = 0;
        for (int j = 0; j < 300; j++) begin @(negedge clk); if (spdif_out) cnt++; end
        check(cnt == 0, "R2", "line high with only transmit enable", cnt, 0);
        check(rd_idx == 0, "R2", "samples taken with only transmit enable", rd_idx, 0);
        soft_reset();
        wr(2'd0, 32'h2);
        cnt = 0;
        for (int j = 0; j < 300; j++) begin @(negedge clk); if (spdif_out) cnt++; end
        check(cnt == 0, "R2", "line high with only global enable", cnt, 0);
        check(rd_idx == 0, "R2", "samples taken with only global enable", rd_idx, 0);

        // R11: register widths and soft reset
        soft_reset();
        wr(2'd1, 32'hFFFF_FFFF);
        rd(2'd1, r);
        check(r == 32'h8001_01FF, "R11", "config kept bits", r, 32'h8001_01FF);
        wr(2'd3, 32'hFFFF_FEB5);
        rd(2'd3, r);
        check(r == 32'h0000_02B5, "R11", "status high kept bits", r, 32'h2B5);
        wr(2'd0, 32'hFFFF_FFFE);
        rd(2'd0, r);
        check(r == 32'h2, "R11", "control readback", r, 32'h2);
        soft_reset();
        rd(2'd0, r);
        check(r == 32'h0, "R11", "control after soft reset", r, 32'h0);
        rd(2'd1, r);
        check(r == 32'h0, "R11", "config after soft reset", r, 32'h0);

        // Vector table: R3 R4 R5 R6 R7 R8 R9
        for (int v = 0; v < NVEC; v++) begin
            soft_reset();
            set_fifo(int'(VECS[v].nsmp), VECS[v].sl, VECS[v].sr);
            wr(2'd1, mk_cfg(VECS[v].mono, VECS[v].na, VECS[v].ratio, VECS[v].fmt, 0, 1));
            H = int'(VECS[v].ratio) + 1;
            wr(2'd0, 32'h2);
            capture(4 * 64 * H + 2);
            cnt = 0;
            while (cnt < RAW_MAX && raw[cnt]) cnt++;
            check(cnt == 3 * H, "R3", "first high run length", cnt, 3 * H);
            cnt = 0;
            for (int k = 0; k < 4 * 64; k++)
                for (int j = 1; j < H; j++)
                    if (raw[k*H + j] != raw[k*H]) cnt++;
            check(cnt == 0, "R3", "level change inside half-cell", cnt, 0);
            for (int s = 0; s < 4; s++) begin
                int          idx;
                logic [23:0] ea;
                logic        ev;
                string       areq;
                idx  = VECS[v].mono ? s / 2 : s;
                ea   = (idx < int'(VECS[v].nsmp)) ? ((idx % 2 == 1) ? VECS[v].er : VECS[v].el) : 24'h0;
                ev   = VECS[v].na || (idx >= int'(VECS[v].nsmp));
                areq = VECS[v].mono ? "R7" : ((idx >= int'(VECS[v].nsmp)) ? "R8" : "R6");
                decode(s, pre, w, berr);
                check(pre == exp_pre(s), "R5", "preamble", 32'(pre), 32'(exp_pre(s)));
                check(w[27:4] == ea, areq, "audio field", 32'(w[27:4]), 32'(ea));
                check(w[28] == ev, VECS[v].na ? "R9" : "R8", "validity", 32'(w[28]), 32'(ev));
                check(^w[31:4] == 1'b0 && w[29] == 1'b0, "R4", "parity and user bit", w, 32'h0);
                check(berr == 0, "R4", "missing cell transition", berr, 0);
            end
        end

        // R10 R9 R5: status from registers over a full block
        soft_reset();
        set_fifo(0, 24'h0, 24'h0);
        wr(2'd2, 32'hC3A5_0F5C);
        wr(2'd3, 32'h0000_02B5);
        wr(2'd1, mk_cfg(0, 1, 5'd0, 2'd2, 1, 1));
        H = 1;
        wr(2'd0, 32'h2);
        capture(194 * 128 + 2);
        begin
            int cs_bad, v_bad, b_bad, p_bad;
            logic [41:0] csv;
            logic        ec;
            csv = {10'h2B5, 32'hC3A5_0F5C};
            cs_bad = 0; v_bad = 0; b_bad = 0; p_bad = 0;
            for (int s = 0; s < 2 * 193; s++) begin
                int f;
                f  = (s / 2) % 192;
                ec = (f < 42) ? csv[f] : 1'b0;
                if (f == 1) ec = 1'b1;
                decode(s, pre, w, berr);
                if (w[30] != ec) cs_bad++;
                if (w[28] != 1'b1) v_bad++;
                b_bad += berr;
                if (^w[31:4]) p_bad++;
            end
            check(cs_bad == 0, "R10", "status bit mismatches", cs_bad, 0);
            check(v_bad == 0, "R9", "validity low in non-audio", v_bad, 0);
            check(b_bad == 0 && p_bad == 0, "R4", "block coding errors", b_bad + p_bad, 0);
        end
        decode(2 * 191, pre, w, berr);
        check(pre == 8'b1110_0010, "R5", "last frame of block preamble", 32'(pre), 32'hE2);
        decode(2 * 192, pre, w, berr);
        check(pre == 8'b1110_1000, "R5", "next block start preamble", 32'(pre), 32'hE8);

        // R10: status source off
        soft_reset();
        wr(2'd2, 32'hFFFF_FFFF);
        wr(2'd3, 32'h3FF);
        wr(2'd1, mk_cfg(0, 0, 5'd0, 2'd2, 0, 1));
        wr(2'd0, 32'h2);
        capture(3 * 128 + 2);
        cnt = 0;
        for (int s = 0; s < 6; s++) begin
            decode(s, pre, w, berr);
            if (w[30]) cnt++;
        end
        check(cnt == 0, "R10", "status bits with register source off", cnt, 0);

        // R12: soft reset while transmitting
        soft_reset();
        cnt = 0;
        for (int j = 0; j < 200; j++) begin @(negedge clk); if (spdif_out) cnt++; end
        check(cnt == 0, "R12", "line high after soft reset", cnt, 0);
        rd(2'd2, r);
        check(r == 32'h0, "R12", "status register after soft reset", r, 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule